// File: doc/BRIEF.md
# Banked Peripheral Register Window

This block gives a processor access to many copies of one 8-bit peripheral control register while using only two addresses on its register bus. A select register at its own address holds a unit number. The shared control address then reads and writes the control register of the unit that the select register names. If the select value names a unit that does not exist, unit 0 is used instead. Every control register drives its unit through a flattened output bus.

Each unit also has a sticky pending-interrupt flag. A flag is set by an on-chip event pulse for that unit, or by a falling edge on that unit's asynchronous active-low interrupt pin. A pin first passes through a two-flop synchronizer before edge detection. A flag stays set whether or not its unit is selected, and it clears only when an acknowledge strobe names that unit. Several events that arrive while a flag is already set produce a single pending request. Reset is asynchronous and active low, and the block leaves reset synchronously to its single rising-edge clock.

Top module: `banked_reg_window`

## Requirements
- R1: After reset the select register reads 0, every control register is 0 and every pending flag is 0.
- R2: A bus write to the select address (parameter SEL_ADDR, default 0x8E) stores all 8 data bits, and a later read of that address returns exactly the value written, in range or not.
- R3: A bus write to the control address (parameter CTRL_ADDR, default 0x88) changes only the control register of the unit named by the select register, on the next rising edge. Unit k occupies bits [8k+7:8k] of ctrl_out.
- R4: A read of the control address returns the 8-bit control register of the selected unit in the same cycle.
- R5: When the select value is N_UNITS or larger, reads and writes of the control address use unit 0.
- R6: A bus write to any other address changes no register, and a read of any other address returns 0.
- R7: An event pulse for a unit sets that unit's pending flag on the next rising edge. The flag stays set, whatever the select register holds, until that unit is acknowledged, so repeated events while pending give one request.
- R8: An acknowledge (ack_valid high, ack_idx = unit number) clears only that unit's flag on the next rising edge. An event for the same unit in the same cycle keeps the flag set.
- R9: A falling edge on irq_pin_n[k] sets flag k on the third rising edge after the pin changes, and not on the second. A rising edge or a steady level sets no flag.
- R10: The block stays in reset for the first two rising edges after rst_n is released, so a bus write presented at the first of those edges is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge only |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Register bus write strobe |
| bus_rdata | output | 8 | Register bus read data, combinational |
| unit_evt | input | N_UNITS | Synchronous event pulse, one bit per unit |
| irq_pin_n | input | N_UNITS | Asynchronous active-low interrupt pins, one per unit |
| ack_valid | input | 1 | Interrupt service acknowledge strobe |
| ack_idx | input | IDX_W | Unit number being acknowledged |
| irq_pend | output | N_UNITS | Pending-interrupt flags |
| ctrl_out | output | 8*N_UNITS | All control registers, unit k at bits [8k+7:8k] |

## Verification
The hardest situation to reach is a flag that is raised while its unit is not selected, is hit again by further events, and must still give exactly one request. The stimulus points the select register at another unit, fires the same unit's event several times, and then acknowledges once. It then confirms the flag is clear after that single service. The bench also presents an event in the same cycle as an acknowledge. It counts clock edges from a falling pin edge to check the third-edge rule of the synchronizer path, and it writes out-of-range select values to show that unit 0 is used.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int REG_W = 8;
  typedef logic [REG_W-1:0] reg_t;

  // Map a select value onto a unit index; values past the last unit use unit 0.
  function automatic int unsigned pick_unit(input reg_t sel, input int unsigned n);
    int unsigned s;
    s = {24'd0, sel};
    return (s < n) ? s : 0;
  endfunction
endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ni = stage_q[1];
endmodule

// File: rtl/bank_pin_sync.sv
module bank_pin_sync #(
  parameter int N_UNITS = 4
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] pin_n,
  output logic [N_UNITS-1:0] fall
);
  logic [N_UNITS-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pin_n;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign fall = last_q & ~sync_q;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_chk
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
      fall[i] |=> !fall[i]); // R9
  end
endmodule

// File: rtl/bank_ctrl_regs.sv
module bank_ctrl_regs
  import bank_pkg::*;
#(
  parameter int N_UNITS = 4
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] wr_en,
  input  reg_t               wdata,
  output reg_t               ctrl_q [N_UNITS]
);
  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)       ctrl_q[i] <= '0;
      else if (wr_en[i]) ctrl_q[i] <= wdata;
    end

    AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
      !wr_en[i] |=> $stable(ctrl_q[i])); // R3
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(wr_en)); // R3
endmodule

// File: rtl/bank_pend_flags.sv
module bank_pend_flags #(
  parameter int N_UNITS = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] evt,
  input  logic               ack_valid,
  input  logic [IDX_W-1:0]   ack_idx,
  output logic [N_UNITS-1:0] pend_q
);
  logic [N_UNITS-1:0] clr, pend_d;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    assign clr[i]    = ack_valid && (ack_idx == IDX_W'(i));
    assign pend_d[i] = evt[i] | (pend_q[i] & ~clr[i]);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_ni)
      evt[i] |=> pend_q[i]); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
      (pend_q[i] && !clr[i]) |=> pend_q[i]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
      (clr[i] && !evt[i]) |=> !pend_q[i]); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_ni)
      (!pend_q[i] && !evt[i]) |=> !pend_q[i]); // R7
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end
endmodule

// File: rtl/banked_reg_window.sv
module banked_reg_window
  import bank_pkg::*;
#(
  parameter int         N_UNITS   = 4,
  parameter logic [7:0] SEL_ADDR  = 8'h8E,
  parameter logic [7:0] CTRL_ADDR = 8'h88,
  localparam int        IDX_W     = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_we,
  output logic [7:0]           bus_rdata,
  input  logic [N_UNITS-1:0]   unit_evt,
  input  logic [N_UNITS-1:0]   irq_pin_n,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  output logic [N_UNITS-1:0]   irq_pend,
  output logic [8*N_UNITS-1:0] ctrl_out
);
  logic               rst_ni;
  reg_t               sel_q;
  logic               sel_en;
  logic               sel_hit, ctrl_hit;
  logic [IDX_W-1:0]   eff_idx;
  logic [N_UNITS-1:0] wr_en;
  logic [N_UNITS-1:0] pin_fall;
  logic [N_UNITS-1:0] evt_all;
  reg_t               ctrl_q [N_UNITS];

  bank_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  // Address decode
  assign sel_hit  = (bus_addr == SEL_ADDR);
  assign ctrl_hit = (bus_addr == CTRL_ADDR);
  assign sel_en   = bus_we && sel_hit;

  // Select register
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (sel_en) sel_q <= bus_wdata;
  end

  always_comb eff_idx = IDX_W'(pick_unit(sel_q, N_UNITS));

  // Unit write decoder
  for (genvar i = 0; i < N_UNITS; i++) begin : g_dec
    assign wr_en[i] = bus_we && ctrl_hit && (eff_idx == IDX_W'(i));
    assign ctrl_out[8*i +: 8] = ctrl_q[i];
  end

  bank_ctrl_regs #(.N_UNITS(N_UNITS)) u_regs (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr_en  (wr_en),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q)
  );

  // Read multiplexer
  always_comb begin
    if (sel_hit)       bus_rdata = sel_q;
    else if (ctrl_hit) bus_rdata = ctrl_q[eff_idx];
    else               bus_rdata = '0;
  end

  bank_pin_sync #(.N_UNITS(N_UNITS)) u_pins (
    .clk    (clk),
    .rst_ni (rst_ni),
    .pin_n  (irq_pin_n),
    .fall   (pin_fall)
  );

  assign evt_all = unit_evt | pin_fall;

  bank_pend_flags #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_pend (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .evt       (evt_all),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .pend_q    (irq_pend)
  );

  AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && bus_addr == SEL_ADDR) |=>
      (bus_addr != SEL_ADDR || bus_rdata == $past(bus_wdata))); // R2
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_addr == CTRL_ADDR && {24'd0, sel_q} < N_UNITS) |->
      (bus_rdata == ctrl_out[int'(sel_q)*8 +: 8])); // R4
  AST_FALLBACK_WR: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && bus_addr == CTRL_ADDR && {24'd0, sel_q} >= N_UNITS) |=>
      (ctrl_out[7:0] == $past(bus_wdata))); // R5
endmodule

// File: tb/tb_banked_reg_window.sv
module tb_banked_reg_window;
  localparam int N = 4;
  localparam logic [7:0] SEL_A   = 8'h8E;
  localparam logic [7:0] CTRL_A  = 8'h88;
  localparam logic [7:0] OTHER_A = 8'h90;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [7:0]     bus_addr, bus_wdata, bus_rdata;
  logic           bus_we;
  logic [N-1:0]   unit_evt, irq_pin_n, irq_pend;
  logic           ack_valid;
  logic [1:0]     ack_idx;
  logic [8*N-1:0] ctrl_out;

  banked_reg_window #(.N_UNITS(N), .SEL_ADDR(SEL_A), .CTRL_ADDR(CTRL_A)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .unit_evt(unit_evt),
    .irq_pin_n(irq_pin_n), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .irq_pend(irq_pend), .ctrl_out(ctrl_out)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    int          kind;   // 0 read data, 1 pending flags, 2 control bus
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    finished = 0;

  logic [7:0] m_sel;
  logic [7:0] m_ctrl [N];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int m_eff();
    return (int'(m_sel) < N) ? int'(m_sel) : 0;
  endfunction

  function automatic logic [31:0] m_flat();
    logic [31:0] f;
    for (int k = 0; k < N; k++) f[8*k +: 8] = m_ctrl[k];
    return f;
  endfunction

  task automatic expect_at(input int kind, input logic [31:0] v, input string tag, input int d);
    item_t it;
    it.due = cyc + d; it.kind = kind; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares queued expectations as results appear
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        logic [31:0] got;
        it = sb.pop_front();
        case (it.kind)
          0:       got = {24'd0, bus_rdata};
          1:       got = {28'd0, irq_pend};
          default: got = ctrl_out;
        endcase
        total++;
        if (it.due != cyc || got !== it.exp) begin
          bad++;
          $display("FAIL %s: actual %h expected %h (cycle %0d due %0d)",
                   it.tag, got, it.exp, cyc, it.due);
        end
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00;
    if (a == SEL_A) m_sel = d;
    else if (a == CTRL_A) m_ctrl[m_eff()] = d;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [7:0] v, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    expect_at(0, {24'd0, v}, tag, 1);
    @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [N-1:0] e);
    @(negedge clk);
    unit_evt = e;
    @(negedge clk);
    unit_evt = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    unit_evt = '0; irq_pin_n = '1; ack_valid = 1'b0; ack_idx = '0;
    m_sel = '0;
    for (int k = 0; k < N; k++) m_ctrl[k] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    expect_at(2, 32'h0, "R1 ctrl reset", 1);
    expect_at(1, 32'h0, "R1 pend reset", 1);
    @(negedge clk);

    // R10: write presented at first edge after release is ignored
    rst_n = 1'b1; bus_addr = SEL_A; bus_wdata = 8'h03; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    repeat (2) @(negedge clk);
    bus_rd(SEL_A, 8'h00, "R10 sel after early write");
    bus_rd(CTRL_A, 8'h00, "R1 ctrl read after reset");

    // R3: per-unit writes only touch the selected unit
    for (int u = 0; u < N; u++) begin
      bus_wr(SEL_A, 8'(u));
      bus_wr(CTRL_A, 8'(8'h3C + 8'h21 * u));
      expect_at(2, m_flat(), "R3 unit write", 1);
      @(negedge clk);
    end

    // R4 and R2: read back each unit through the window
    for (int u = N - 1; u >= 0; u--) begin
      bus_wr(SEL_A, 8'(u));
      bus_rd(SEL_A, 8'(u), "R2 sel readback");
      bus_rd(CTRL_A, m_ctrl[u], "R4 window read");
    end

    // R5: out-of-range select falls back to unit 0
    bus_wr(SEL_A, 8'(N));
    bus_rd(CTRL_A, m_ctrl[0], "R5 read fallback at N");
    bus_wr(CTRL_A, 8'h77);
    expect_at(2, m_flat(), "R5 write fallback at N", 1);
    @(negedge clk);
    bus_wr(SEL_A, 8'hFF);
    bus_rd(SEL_A, 8'hFF, "R2 out-of-range sel readback");
    bus_wr(CTRL_A, 8'hC4);
    bus_rd(CTRL_A, 8'hC4, "R5 read fallback at FF");
    expect_at(2, m_flat(), "R5 write fallback at FF", 1);
    @(negedge clk);

    // R6: other address has no effect and reads 0
    bus_wr(OTHER_A, 8'hEE);
    expect_at(2, m_flat(), "R6 ctrl untouched", 1);
    @(negedge clk);
    bus_rd(SEL_A, 8'hFF, "R6 sel untouched");
    bus_rd(OTHER_A, 8'h00, "R6 other read");

    // R7: event sets flag next edge; sticky while unselected; one request
    bus_wr(SEL_A, 8'h02);
    @(negedge clk);
    unit_evt = 4'b0010;
    expect_at(1, 32'h2, "R7 event sets flag", 1);
    @(negedge clk);
    unit_evt = '0;
    bus_wr(SEL_A, 8'h03);
    pulse_evt(4'b0010);
    pulse_evt(4'b0010);
    repeat (3) @(negedge clk);
    expect_at(1, 32'h2, "R7 flag held while unselected", 1);
    @(negedge clk);
    ack_valid = 1'b1; ack_idx = 2'd1;
    expect_at(1, 32'h0, "R7 single service clears", 1);
    @(negedge clk);
    ack_valid = 1'b0;
    expect_at(1, 32'h0, "R7 no second request", 2);
    repeat (2) @(negedge clk);

    // R8: event in same cycle as ack keeps flag; ack only clears its unit
    pulse_evt(4'b0100);
    @(negedge clk);
    unit_evt = 4'b0100; ack_valid = 1'b1; ack_idx = 2'd2;
    expect_at(1, 32'h4, "R8 event wins over ack", 1);
    @(negedge clk);
    unit_evt = '0;
    expect_at(1, 32'h0, "R8 ack clears", 1);
    @(negedge clk);
    ack_valid = 1'b0;
    pulse_evt(4'b1001);
    @(negedge clk);
    ack_valid = 1'b1; ack_idx = 2'd3;
    expect_at(1, 32'h1, "R8 ack clears only indexed unit", 1);
    @(negedge clk);
    ack_idx = 2'd0;
    expect_at(1, 32'h0, "R8 ack unit 0", 1);
    @(negedge clk);
    ack_valid = 1'b0;

    // R9: falling pin edge sets flag on third edge, not second
    @(negedge clk);
    irq_pin_n[0] = 1'b0;
    expect_at(1, 32'h0, "R9 not yet at second edge", 2);
    expect_at(1, 32'h1, "R9 set at third edge", 3);
    repeat (5) @(negedge clk);
    irq_pin_n[0] = 1'b1; ack_valid = 1'b1; ack_idx = 2'd0;
    expect_at(1, 32'h0, "R9 ack after pin event", 1);
    @(negedge clk);
    ack_valid = 1'b0;
    expect_at(1, 32'h0, "R9 rising edge sets nothing", 4);
    repeat (6) @(negedge clk);
    irq_pin_n[3] = 1'b0;
    expect_at(1, 32'h8, "R9 pin 3 falling edge", 3);
    repeat (6) @(negedge clk);
    expect_at(1, 32'h8, "R9 steady low gives no new change", 1);

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    finished = 1;
    finish_run();
  end
endmodule